// File: doc/BRIEF.md
# Triple-Channel Majority Voter with Channel Isolation and Readmission

This block sits behind three identical processing channels. Each channel computes the same output word. On every vote strobe the block combines the words that the healthy channels present into one voted word. It also keeps a health state for every channel. While all three channels are in service, the voted word is the bitwise two-of-three majority. A channel that persistently disagrees with that majority, or that fails to present valid data, is taken out of service after a programmable number of consecutive strobes.

With one channel out, the block carries on as a two-channel comparator. It forwards the word only when the two survivors agree. Any mismatch between them forces the most restrictive output value and raises a fault; the block does not choose between them. A removed channel goes back into service in two steps. First a readmission request moves it into a synchronising state, in which it has no say in the vote. Then an explicit completion pulse, given after the two survivors have brought its state up to date, returns it to service.

Top module: `tmr_voter`

## Requirements
- R1: After reset all three channels read ONLINE, the output word equals SAFE_WORD, and fault and out_valid are low.
- R2: out_valid goes high exactly one clock after a cycle with vote_strobe high. out_data and fault change only in that clock and hold their values between strobes.
- R3: When all three ONLINE channels present valid data, out_data is the bitwise two-of-three majority of the three words and fault is low.
- R4: With all three channels ONLINE, a channel counts a miss on a strobe when its valid is low or its word differs from the majority. It becomes DISCONNECTED on the strobe that completes PERSIST consecutive misses. A strobe without a miss clears its count.
- R5: When exactly two valid words take part in the vote, out_data is their common word if they agree. If they differ, out_data is SAFE_WORD and fault is high.
- R6: When fewer than two ONLINE channels present valid data, out_data is SAFE_WORD and fault is high.
- R7: No channel is disconnected while fewer than three channels are ONLINE. No channel is disconnected when two channels complete their miss run on the same strobe. At most one channel is ever outside ONLINE.
- R8: readmit_req[i] moves channel i from DISCONNECTED to SYNCING one clock later, provided the other two are ONLINE. The request has no effect on a channel in any other state. A SYNCING channel's data and valid take no part in the vote.
- R9: update_done[i] moves channel i from SYNCING to ONLINE one clock later, provided the other two are ONLINE. It has no effect on a channel in any other state.
- R10: Status encoding per channel is DISCONNECTED = 2'b00, ONLINE = 2'b01, SYNCING = 2'b10. Channel i occupies ch_status[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vote_strobe | input | 1 | Evaluate one vote in this cycle |
| ch_valid | input | 3 | Per-channel data valid, bit i for channel i |
| ch_data | input | 3 x W | Per-channel output word, ch_data[i] for channel i |
| readmit_req | input | 3 | Request to start resynchronising a disconnected channel |
| update_done | input | 3 | The state update of a synchronising channel is complete |
| out_data | output | W | Voted word |
| out_valid | output | 1 | One-cycle pulse marking a new vote result |
| fault | output | 1 | No trustworthy majority at the last vote |
| ch_status | output | 3 x 2 | Per-channel health state |

## Verification
The hardest situation to reach is the one where two channels complete their miss run on the same strobe. Whether either of them may be removed depends on counts that only accumulate over several consecutive strobes. The stimulus withholds valid from two channels for PERSIST strobes in a row. It then checks that the output fails safe and that all three channels remain ONLINE. A second sequence covers the full repair path. It isolates a channel, drives two-channel agreement and disagreement, and presents garbage from the synchronising channel to show that it is excluded. It also issues completion pulses to channels in the wrong state before the real readmission.

// File: rtl/tmr_voter_pkg.sv
package tmr_voter_pkg;

  localparam int NCH = 3;

  typedef enum logic [1:0] {
    CH_DISC   = 2'b00,
    CH_ONLINE = 2'b01,
    CH_SYNC   = 2'b10
  } ch_state_e;

endpackage

// File: rtl/tmr_vote_core.sv
// Combinational vote over the channels currently in service.
module tmr_vote_core #(
  parameter int             W         = 8,
  parameter logic [W-1:0]   SAFE_WORD = '0
) (
  input  logic [2:0][W-1:0] data,
  input  logic [2:0]        valid,
  input  logic [2:0]        online,
  output logic [W-1:0]      voted,
  output logic              bad,
  output logic [2:0]        miss
);

  logic [2:0]   part;
  logic [W-1:0] maj;
  logic [2:0]   ne;

  always_comb begin
    part = online & valid;
    maj  = (data[0] & data[1]) | (data[0] & data[2]) | (data[1] & data[2]);
    for (int i = 0; i < 3; i++) begin
      ne[i] = (data[i] != maj);
    end

    voted = SAFE_WORD;
    bad   = 1'b1;
    case (part)
      3'b111: begin
        voted = maj;
        bad   = 1'b0;
      end
      3'b011: if (data[0] == data[1]) begin
        voted = data[0];
        bad   = 1'b0;
      end
      3'b101: if (data[0] == data[2]) begin
        voted = data[0];
        bad   = 1'b0;
      end
      3'b110: if (data[1] == data[2]) begin
        voted = data[1];
        bad   = 1'b0;
      end
      default: ;
    endcase

    miss = (online & ~valid) | ((part == 3'b111) ? ne : 3'b000);
  end

endmodule

// File: rtl/tmr_chan_health.sv
// Health state and persistence counter for one channel.
module tmr_chan_health
  import tmr_voter_pkg::*;
#(
  parameter int PERSIST = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe,
  input  logic      all_online,
  input  logic      pair_online,
  input  logic      miss,
  input  logic      grant,
  input  logic      readmit,
  input  logic      upd_done,
  output ch_state_e state,
  output logic      trip
);

  localparam int             CW  = $clog2(PERSIST + 1);
  localparam logic [CW-1:0]  LIM = CW'(PERSIST - 1);
  localparam logic [CW-1:0]  CAP = CW'(PERSIST);

  ch_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign trip  = strobe && all_online && (state_q == CH_ONLINE) && miss && (cnt_q >= LIM);
  assign state = state_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      CH_ONLINE: begin
        if (strobe) begin
          if (!all_online) begin
            cnt_d = '0;
          end else if (miss) begin
            if (grant) begin
              state_d = CH_DISC;
              cnt_d   = '0;
            end else if (cnt_q < CAP) begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            cnt_d = '0;
          end
        end
      end
      CH_DISC: begin
        cnt_d = '0;
        if (readmit && pair_online) state_d = CH_SYNC;
      end
      CH_SYNC: begin
        cnt_d = '0;
        if (upd_done && pair_online) state_d = CH_ONLINE;
      end
      default: begin
        cnt_d   = '0;
        state_d = CH_DISC;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_ONLINE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/tmr_voter.sv
module tmr_voter
  import tmr_voter_pkg::*;
#(
  parameter int           W         = 8,
  parameter int           PERSIST   = 3,
  parameter logic [W-1:0] SAFE_WORD = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vote_strobe,
  input  logic [NCH-1:0]        ch_valid,
  input  logic [NCH-1:0][W-1:0] ch_data,
  input  logic [NCH-1:0]        readmit_req,
  input  logic [NCH-1:0]        update_done,
  output logic [W-1:0]          out_data,
  output logic                  out_valid,
  output logic                  fault,
  output logic [NCH-1:0][1:0]   ch_status
);

  logic [NCH-1:0] online;
  logic [NCH-1:0] pair_ok;
  logic [NCH-1:0] miss;
  logic [NCH-1:0] trip;
  logic [NCH-1:0] grant;
  logic           all_online;
  logic [W-1:0]   voted;
  logic           bad;

  logic [W-1:0]   data_q, data_d;
  logic           fault_q, fault_d;
  logic           valid_q, valid_d;

  assign all_online = &online;
  assign grant      = $onehot(trip) ? trip : '0;

  tmr_vote_core #(.W(W), .SAFE_WORD(SAFE_WORD)) u_core (
    .data  (ch_data),
    .valid (ch_valid),
    .online(online),
    .voted (voted),
    .bad   (bad),
    .miss  (miss)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int OA = (g + 1) % NCH;
    localparam int OB = (g + 2) % NCH;
    ch_state_e st;

    assign pair_ok[g]   = online[OA] & online[OB];
    assign online[g]    = (st == CH_ONLINE);
    assign ch_status[g] = st;

    tmr_chan_health #(.PERSIST(PERSIST)) u_health (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (vote_strobe),
      .all_online (all_online),
      .pair_online(pair_ok[g]),
      .miss       (miss[g]),
      .grant      (grant[g]),
      .readmit    (readmit_req[g]),
      .upd_done   (update_done[g]),
      .state      (st),
      .trip       (trip[g])
    );
  end

  always_comb begin
    data_d  = data_q;
    fault_d = fault_q;
    valid_d = vote_strobe;
    if (vote_strobe) begin
      data_d  = voted;
      fault_d = bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= SAFE_WORD;
      fault_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      fault_q <= fault_d;
      valid_q <= valid_d;
    end
  end

  assign out_data  = data_q;
  assign fault     = fault_q;
  assign out_valid = valid_q;

endmodule

// File: rtl/tmr_voter_chk.sv
module tmr_voter_chk #(
  parameter int           W         = 8,
  parameter logic [W-1:0] SAFE_WORD = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vote_strobe,
  input logic [2:0]       update_done,
  input logic [2:0]       readmit_req,
  input logic [W-1:0]     out_data,
  input logic             out_valid,
  input logic             fault,
  input logic [2:0][1:0]  ch_status
);

  logic [2:0] not_on;
  always_comb begin
    for (int i = 0; i < 3; i++) not_on[i] = (ch_status[i] != 2'b01);
  end

  assert_single_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(not_on) <= 1);

  assert_fault_safe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (out_data == SAFE_WORD));

  assert_valid_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vote_strobe |=> out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vote_strobe |=> ($stable(out_data) && $stable(fault) && !out_valid));

  for (genvar g = 0; g < 3; g++) begin : g_ch
    assert_status_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ch_status[g] != 2'b11);

    assert_sync_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_status[g] == 2'b10) ##1 (ch_status[g] == 2'b01) |-> $past(update_done[g]));

    assert_no_direct_rejoin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_status[g] == 2'b00) |=> (ch_status[g] != 2'b01));

    assert_sync_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_status[g] == 2'b00) ##1 (ch_status[g] == 2'b10) |-> $past(readmit_req[g]));

    assert_disc_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_status[g] == 2'b01) ##1 (ch_status[g] == 2'b00) |-> $past(vote_strobe));
  end

endmodule

bind tmr_voter tmr_voter_chk #(.W(W), .SAFE_WORD(SAFE_WORD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vote_strobe(vote_strobe),
  .update_done(update_done),
  .readmit_req(readmit_req),
  .out_data   (out_data),
  .out_valid  (out_valid),
  .fault      (fault),
  .ch_status  (ch_status)
);

// File: tb/tmr_voter_bench.sv
`timescale 1ns/1ps
module tmr_voter_bench;

  localparam int         W    = 8;
  localparam int         P    = 3;
  localparam logic [7:0] SAFE = 8'h00;
  localparam logic [1:0] S_DISC = 2'b00, S_ON = 2'b01, S_SYNC = 2'b10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             vote_strobe = 1'b0;
  logic [2:0]       ch_valid = '0;
  logic [2:0][7:0]  ch_data = '0;
  logic [2:0]       readmit_req = '0;
  logic [2:0]       update_done = '0;
  logic [7:0]       out_data;
  logic             out_valid;
  logic             fault;
  logic [2:0][1:0]  ch_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] q_data[$];
  logic       q_fault[$];
  string      q_tag[$];

  logic [1:0] mst[3];
  int         mcnt[3];

  always #2.5 clk = ~clk;

  tmr_voter #(.W(W), .PERSIST(P), .SAFE_WORD(SAFE)) u_tmr_voter (
    .clk(clk), .rst_n(rst_n), .vote_strobe(vote_strobe), .ch_valid(ch_valid),
    .ch_data(ch_data), .readmit_req(readmit_req), .update_done(update_done),
    .out_data(out_data), .out_valid(out_valid), .fault(fault), .ch_status(ch_status)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", 8'h1, 8'h0);
      end else begin
        logic [7:0] ed;
        logic       ef;
        string      t;
        ed = q_data.pop_front();
        ef = q_fault.pop_front();
        t  = q_tag.pop_front();
        check(out_data == ed, {t, " data"}, out_data, ed);
        check(fault == ef, {t, " fault"}, {7'd0, fault}, {7'd0, ef});
      end
    end
  end

  // Driver: applies one vote and pushes the expected result from the requirement model.
  task automatic vote(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                      input logic [2:0] v, input string tag);
    logic [2:0][7:0] d;
    logic [2:0] on, part, miss, trip;
    logic [7:0] maj, ed;
    logic ef;
    int non;
    d = {c, b, a};
    non = 0;
    for (int i = 0; i < 3; i++) begin
      on[i] = (mst[i] == S_ON);
      non += on[i];
    end
    part = on & v;
    maj = (a & b) | (a & c) | (b & c);
    ed = SAFE; ef = 1'b1;
    miss = on & ~v;
    if (part == 3'b111) begin
      ed = maj; ef = 1'b0;
      for (int i = 0; i < 3; i++) if (d[i] != maj) miss[i] = 1'b1;
    end else if ($countones(part) == 2) begin
      logic [7:0] x, y;
      x = part[0] ? a : b;
      y = part[2] ? c : b;
      if (x == y) begin ed = x; ef = 1'b0; end
    end
    trip = '0;
    for (int i = 0; i < 3; i++)
      trip[i] = (non == 3) && miss[i] && (mcnt[i] >= P - 1);
    for (int i = 0; i < 3; i++) begin
      if (mst[i] == S_ON) begin
        if (non != 3) mcnt[i] = 0;
        else if (miss[i]) begin
          if ($countones(trip) == 1 && trip[i]) begin mst[i] = S_DISC; mcnt[i] = 0; end
          else if (mcnt[i] < P) mcnt[i]++;
        end else mcnt[i] = 0;
      end
    end
    @(negedge clk);
    ch_data = d; ch_valid = v; vote_strobe = 1'b1;
    q_data.push_back(ed); q_fault.push_back(ef); q_tag.push_back(tag);
    @(negedge clk);
    vote_strobe = 1'b0; ch_valid = '0;
  endtask

  task automatic pulse_readmit(input int i);
    if (mst[i] == S_DISC && mst[(i+1)%3] == S_ON && mst[(i+2)%3] == S_ON) mst[i] = S_SYNC;
    @(negedge clk); readmit_req[i] = 1'b1;
    @(negedge clk); readmit_req[i] = 1'b0;
  endtask

  task automatic pulse_done(input int i);
    if (mst[i] == S_SYNC && mst[(i+1)%3] == S_ON && mst[(i+2)%3] == S_ON) mst[i] = S_ON;
    @(negedge clk); update_done[i] = 1'b1;
    @(negedge clk); update_done[i] = 1'b0;
  endtask

  task automatic check_status(input string tag);
    for (int i = 0; i < 3; i++)
      check(ch_status[i] == mst[i], tag, {6'd0, ch_status[i]}, {6'd0, mst[i]});
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2: watchdog expired, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin mst[i] = S_ON; mcnt[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_data == SAFE, "R1 out_data", out_data, SAFE);
    check(!fault && !out_valid, "R1 flags", {6'd0, fault, out_valid}, 8'h0);
    check_status("R1 status");
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R2 no strobe no valid", {7'd0, out_valid}, 8'h0);

    // R3 majority
    vote(8'h3C, 8'h3C, 8'h3C, 3'b111, "R3 all agree");
    vote(8'h0F, 8'h33, 8'h55, 3'b111, "R3 bitwise majority");
    vote(8'hA1, 8'hA1, 8'h5E, 3'b111, "R3 one outlier");
    vote(8'h11, 8'h11, 8'h11, 3'b111, "R4 clear counts");
    repeat (2) @(negedge clk);
    check(out_data == 8'h11, "R2 hold between strobes", out_data, 8'h11);

    // R4 two misses then agreement keeps the channel
    vote(8'h20, 8'h20, 8'h21, 3'b111, "R4 miss1");
    vote(8'h20, 8'h20, 8'h21, 3'b111, "R4 miss2");
    vote(8'h20, 8'h20, 8'h20, 3'b111, "R4 count reset");
    vote(8'h20, 8'h20, 8'h21, 3'b111, "R4 miss1b");
    check_status("R4 still online");
    // R4 missing valid counts too; third miss disconnects channel 2
    vote(8'h20, 8'h20, 8'h21, 3'b011, "R4 missing valid");
    vote(8'h20, 8'h20, 8'h22, 3'b111, "R4 third miss");
    check_status("R4 disconnected");
    check(ch_status[2] == S_DISC, "R10 disc code", {6'd0, ch_status[2]}, {6'd0, S_DISC});

    // R5 two-channel mode
    vote(8'h44, 8'h44, 8'hFF, 3'b111, "R5 pair agree");
    vote(8'h44, 8'h45, 8'h44, 3'b111, "R5 pair disagree");
    // R6 and R7: only one valid, no further loss
    vote(8'h44, 8'h44, 8'h44, 3'b010, "R6 single valid");
    vote(8'h44, 8'h44, 8'h44, 3'b010, "R7 single valid 2");
    vote(8'h44, 8'h44, 8'h44, 3'b010, "R7 single valid 3");
    vote(8'h44, 8'h44, 8'h44, 3'b010, "R7 single valid 4");
    check_status("R7 no loss in pair mode");

    // R9 done on a disconnected channel ignored; R8 readmit
    pulse_done(2);
    check_status("R9 done ignored when disconnected");
    pulse_readmit(2);
    check_status("R8 syncing");
    check(ch_status[2] == S_SYNC, "R10 sync code", {6'd0, ch_status[2]}, {6'd0, S_SYNC});
    vote(8'h66, 8'h66, 8'h99, 3'b111, "R8 syncing excluded");
    pulse_done(0);
    check_status("R9 done on online ignored");
    pulse_readmit(1);
    check_status("R8 readmit on online ignored");
    pulse_done(2);
    check_status("R9 rejoined");
    vote(8'h70, 8'h71, 8'h71, 3'b111, "R3 after rejoin");

    // R7 two channels trip together: nobody removed
    vote(8'h10, 8'h10, 8'h10, 3'b111, "R7 clear");
    vote(8'h10, 8'h00, 8'h00, 3'b001, "R7 double miss1");
    vote(8'h10, 8'h00, 8'h00, 3'b001, "R7 double miss2");
    vote(8'h10, 8'h00, 8'h00, 3'b001, "R7 double miss3");
    check_status("R7 double trip keeps all");
    vote(8'h10, 8'h00, 8'h00, 3'b001, "R7 double miss4");
    check_status("R7 saturated keeps all");
    vote(8'h5A, 8'h5A, 8'h5A, 3'b111, "R3 recover");

    repeat (3) @(negedge clk);
    check(q_data.size() == 0, "R2 all results seen", 8'(q_data.size()), 8'h0);
    done = 1;
    summary();
    $finish;
  end

endmodule